// File: doc/BRIEF.md
# Up/Down Position Check Counter

This block keeps an eight-bit running count of tape position pulses, so that a controller can confirm that a reposition moved the tape by the intended distance. A microprocessor drives it through single-cycle command strobes. These commands select up-counting or down-counting, halt the count, zero it, and drop the carry flag. The count direction is held in a small mode register, and each position pulse moves the count one step in that direction.

Whenever the count steps past either end of its range, a sticky carry flag is raised. This covers rolling up from the maximum value to zero, and rolling down from zero to the maximum value. The flag is only meaningful while an operation sequence is active. When the sequence-active input is low, the flag reads as zero and its stored state is discarded. When the readback select bit is set, a readback bus shows the current count; otherwise the bus is zero.

Top module: `pos_track_counter`

## Requirements
- R1: While the mode is up, each cycle with `pos_pulse` high and `cmd_clear` low raises `count` by one on the next clock edge, wrapping from 255 to 0.
- R2: While the mode is down, each cycle with `pos_pulse` high and `cmd_clear` low lowers `count` by one on the next clock edge, wrapping from 0 to 255.
- R3: While the mode is stopped, `count` holds its value regardless of `pos_pulse`.
- R4: `cmd_clear` sets `count` to 0 on the next edge, even if a position pulse arrives in the same cycle.
- R5: An up-count step from 255 sets the carry flag; `carry` reads 1 from the next cycle while `seq_active` stays high.
- R6: A down-count step from 0 also sets the carry flag.
- R7: The carry flag stays set until `cmd_clr_carry` is strobed. If the strobe and a wrap occur in the same cycle, the flag ends up clear.
- R8: `carry` is 0 in any cycle where `seq_active` is 0. A cycle with `seq_active` low erases the stored flag, and any wrap in that cycle is ignored.
- R9: `rdbk` equals `count` while `rdbk_sel` is 1, and is 0 otherwise.
- R10: Mode commands take effect from the next cycle. They rank stop first, then up, then down. If up and down are strobed together, the mode becomes up.
- R11: After reset the mode is stopped, `count` is 0 and the carry flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pos_pulse | input | 1 | One-cycle tape position pulse |
| cmd_up | input | 1 | Strobe: select up-counting |
| cmd_down | input | 1 | Strobe: select down-counting |
| cmd_stop | input | 1 | Strobe: halt counting |
| cmd_clear | input | 1 | Strobe: zero the count |
| cmd_clr_carry | input | 1 | Strobe: clear the carry flag |
| seq_active | input | 1 | Operation sequence in progress; qualifies the carry flag |
| rdbk_sel | input | 1 | Route the count onto the readback bus |
| count | output | 8 | Current count |
| carry | output | 1 | Sticky wrap flag, qualified by `seq_active` |
| rdbk | output | 8 | Readback bus |

## Verification
Directed runs cover the following cases:
- Steady up-counting and down-counting with pulses, which tells direction selection apart from plain stepping.
- Wraps at both ends of the range, which separate the up-wrap and down-wrap carry sources.
- Clear arriving together with a pulse, and up strobed together with down, which exercise each priority rule in isolation.

Random runs mix all strobes, pulses, `seq_active` drops and readback selection on every cycle. A reference model computes the expected value of every output each cycle. This exposes interactions such as a wrap landing in a cycle with `cmd_clr_carry` set or with `seq_active` low.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_UP   = 2'd1,
    MODE_DOWN = 2'd2
  } ptc_mode_e;

  // Next mode from the command strobes: stop, then up, then down.
  function automatic ptc_mode_e mode_next(input ptc_mode_e cur, input logic stp,
                                          input logic up, input logic dn);
    if (stp)     return MODE_IDLE;
    else if (up) return MODE_UP;
    else if (dn) return MODE_DOWN;
    else         return cur;
  endfunction
endpackage

// File: rtl/ptc_mode_ctl.sv
module ptc_mode_ctl
  import ptc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cmd_up,
  input  logic      cmd_down,
  input  logic      cmd_stop,
  output ptc_mode_e mode_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= MODE_IDLE;
    else        mode_q <= mode_next(mode_q, cmd_stop, cmd_up, cmd_down);
  end
endmodule

// File: rtl/ptc_count_core.sv
module ptc_count_core
  import ptc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ptc_mode_e        mode,
  input  logic             pulse,
  input  logic             clear,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic step_en;
  logic [CNT_W-1:0] cnt_d;

  assign step_en  = pulse && !clear && (mode != MODE_IDLE);
  assign wrap_evt = step_en && (((mode == MODE_UP) && (cnt_q == CNT_MAX)) ||
                                ((mode == MODE_DOWN) && (cnt_q == '0)));

  always_comb begin
    cnt_d = cnt_q;
    if (clear)                             cnt_d = '0;
    else if (step_en && mode == MODE_UP)   cnt_d = cnt_q + CNT_ONE;
    else if (step_en && mode == MODE_DOWN) cnt_d = cnt_q - CNT_ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ptc_carry_flag.sv
module ptc_carry_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap_evt,
  input  logic clr_cmd,
  input  logic seq_active,
  output logic carry_q,
  output logic carry_out
);
  always_ff @(posedge clk) begin
    if (!rst_n) carry_q <= 1'b0;
    else        carry_q <= seq_active && !clr_cmd && (carry_q || wrap_evt);
  end

  assign carry_out = carry_q && seq_active;
endmodule

// File: rtl/pos_track_counter.sv
module pos_track_counter
  import ptc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pos_pulse,
  input  logic             cmd_up,
  input  logic             cmd_down,
  input  logic             cmd_stop,
  input  logic             cmd_clear,
  input  logic             cmd_clr_carry,
  input  logic             seq_active,
  input  logic             rdbk_sel,
  output logic [CNT_W-1:0] count,
  output logic             carry,
  output logic [CNT_W-1:0] rdbk
);
  ptc_mode_e mode_q;
  logic      wrap_evt;
  logic      carry_q;

  ptc_mode_ctl u_mode (
    .clk(clk), .rst_n(rst_n), .cmd_up(cmd_up), .cmd_down(cmd_down),
    .cmd_stop(cmd_stop), .mode_q(mode_q)
  );

  ptc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .pulse(pos_pulse),
    .clear(cmd_clear), .cnt_q(count), .wrap_evt(wrap_evt)
  );

  ptc_carry_flag u_carry (
    .clk(clk), .rst_n(rst_n), .wrap_evt(wrap_evt), .clr_cmd(cmd_clr_carry),
    .seq_active(seq_active), .carry_q(carry_q), .carry_out(carry)
  );

  assign rdbk = rdbk_sel ? count : '0;
endmodule

// File: rtl/ptc_checker.sv
module ptc_checker
  import ptc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pos_pulse,
  input logic             cmd_clear,
  input logic             cmd_clr_carry,
  input logic             seq_active,
  input logic             rdbk_sel,
  input ptc_mode_e        mode_q,
  input logic             carry_q,
  input logic [CNT_W-1:0] count,
  input logic             carry,
  input logic [CNT_W-1:0] rdbk
);
  a_r1_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_UP && pos_pulse && !cmd_clear) |=> count == $past(count) + 1'b1);

  a_r2_down_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_DOWN && pos_pulse && !cmd_clear) |=> count == $past(count) - 1'b1);

  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_IDLE && !cmd_clear) |=> $stable(count));

  a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clear |=> count == '0);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_q && seq_active && !cmd_clr_carry) |=> carry_q);

  a_r7_clr_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clr_carry |=> !carry_q);

  a_r8_seq_off: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_active |-> !carry);

  a_r9_readback: assert property (@(posedge clk) disable iff (!rst_n)
    rdbk == (rdbk_sel ? count : '0));
endmodule

bind pos_track_counter ptc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pos_pulse(pos_pulse), .cmd_clear(cmd_clear),
  .cmd_clr_carry(cmd_clr_carry), .seq_active(seq_active), .rdbk_sel(rdbk_sel),
  .mode_q(mode_q), .carry_q(carry_q), .count(count), .carry(carry), .rdbk(rdbk)
);

// File: tb/tb_pos_track_counter.sv
module tb_pos_track_counter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pos_pulse = 0, cmd_up = 0, cmd_down = 0, cmd_stop = 0;
  logic cmd_clear = 0, cmd_clr_carry = 0, seq_active = 0, rdbk_sel = 0;
  logic [7:0] count, rdbk;
  logic carry;

  int n_chk = 0, n_fail = 0;
  int m_mode = 0;          // 0 stopped, 1 up, 2 down
  int m_cnt = 0;
  bit m_cq = 0;

  always #5 clk = ~clk;

  pos_track_counter dut (
    .clk(clk), .rst_n(rst_n), .pos_pulse(pos_pulse), .cmd_up(cmd_up),
    .cmd_down(cmd_down), .cmd_stop(cmd_stop), .cmd_clear(cmd_clear),
    .cmd_clr_carry(cmd_clr_carry), .seq_active(seq_active), .rdbk_sel(rdbk_sel),
    .count(count), .carry(carry), .rdbk(rdbk)
  );

  function automatic int exp_count(int c, int md, bit p, bit clr);
    if (clr) return 0;
    if (p && md == 1) return (c + 1) % 256;
    if (p && md == 2) return (c + 255) % 256;
    return c;
  endfunction

  function automatic bit exp_wrap(int c, int md, bit p, bit clr);
    return p && !clr && ((md == 1 && c == 255) || (md == 2 && c == 0));
  endfunction

  task automatic check(string tag, string what, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // Drive one cycle of stimulus (at negedge), check outputs, advance the model.
  task automatic step(string tag, bit p, bit up, bit dn, bit stp, bit clr,
                      bit clrc, bit seq, bit sel);
    pos_pulse = p; cmd_up = up; cmd_down = dn; cmd_stop = stp;
    cmd_clear = clr; cmd_clr_carry = clrc; seq_active = seq; rdbk_sel = sel;
    #1;
    check(tag, "count", int'(count), m_cnt);
    check(tag, "carry", int'(carry), int'(m_cq && seq));
    check("R9", "rdbk", int'(rdbk), sel ? m_cnt : 0);
    @(posedge clk);
    m_cq = seq && !clrc && (m_cq || exp_wrap(m_cnt, m_mode, p, clr));
    m_cnt = exp_count(m_cnt, m_mode, p, clr);
    m_mode = stp ? 0 : up ? 1 : dn ? 2 : m_mode;
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11: reset state, pulses while stopped do nothing
    step("R11", 1, 0, 0, 0, 0, 0, 1, 1);
    step("R11", 1, 0, 0, 0, 0, 0, 1, 1);
    // R1: up counting
    step("R1", 0, 1, 0, 0, 0, 0, 1, 1);
    repeat (3) step("R1", 1, 0, 0, 0, 0, 0, 1, 1);
    // R4: clear beats a same-cycle pulse
    step("R4", 1, 0, 0, 0, 1, 0, 1, 1);
    step("R4", 0, 0, 0, 0, 0, 0, 1, 1);
    // R10: up and down together -> up; then down alone
    step("R10", 0, 1, 1, 0, 0, 0, 1, 0);
    step("R10", 1, 0, 1, 0, 0, 0, 1, 0);
    step("R10", 0, 0, 0, 0, 1, 0, 1, 1);
    // R6, R2: down wrap from zero sets carry
    step("R6", 1, 0, 0, 0, 0, 0, 1, 1);
    step("R6", 0, 0, 0, 0, 0, 0, 1, 1);
    step("R2", 1, 0, 0, 0, 0, 0, 1, 1);
    // R3: stop holds count
    step("R3", 0, 0, 0, 1, 0, 0, 1, 1);
    repeat (3) step("R3", 1, 0, 0, 0, 0, 0, 1, 1);
    // R7: clear carry command
    step("R7", 0, 0, 0, 0, 0, 1, 1, 1);
    step("R7", 0, 0, 0, 0, 0, 0, 1, 1);
    // R5: up from 254 -> 255 -> 0 sets carry
    step("R5", 0, 1, 0, 0, 0, 0, 1, 1);
    repeat (3) step("R5", 1, 0, 0, 0, 0, 0, 1, 1);
    // R8: drop sequence-active, flag reads zero and is erased
    step("R8", 0, 0, 0, 0, 0, 0, 0, 1);
    step("R8", 0, 0, 0, 0, 0, 0, 1, 1);
    // R7: wrap and clear-carry in the same cycle
    step("R7", 0, 0, 1, 0, 1, 0, 1, 1);
    step("R7", 1, 0, 0, 0, 0, 1, 1, 1);
    step("R7", 0, 0, 0, 0, 0, 0, 1, 1);
    // Random mix: R1 R2 R3 R4 R5 R6 R7 R8 R10 all exercised
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom;
      step("RND", r[0] | r[1], r[2:4] == 0, r[5:7] == 0, r[8:11] == 0,
           r[12:16] == 0, r[17:20] == 0, r[21:24] != 0, r[25]);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule